// File: doc/BRIEF.md
# Split-Word Serial Potentiometer Loader

This block builds the 24-bit setup word for a serial digital potentiometer that tunes an oscillator's control voltage. The host bus is only 16 bits wide, so the word arrives in two writes: an upper write supplies bits 23:8, and a lower write supplies bits 7:0 from the low byte of the bus. The potentiometer has 1024 wiper positions, so the wiper value sits in a 10-bit field of the word. The two halves are held in a staging register. Writing them does not start a transfer.

A separate update strobe copies the staged word into a shift register. The block then sends it over a three-wire serial link: an active-low select, a serial clock and a data line. The serial clock runs at one eighth of the 100 MHz system clock. Data changes while the serial clock is low and is held while it is high. The select is framed by one idle serial-clock period before the first bit and one after the last bit. A busy flag covers the whole frame. The host can refill the staging register during a frame without disturbing the bits already being sent.

Top module: `pot_word_loader`

## Requirements
- R1: After reset, busy is 0, ser_cs_n is 1, ser_sclk is 0 and ser_sdo is 0.
- R2: A write with wr_hi=1 stores wr_data into word bits 23:8. A write with wr_hi=0 stores wr_data[7:0] into word bits 7:0 and ignores wr_data[15:8]. Each half keeps its value when only the other half is written.
- R3: Writes without an update strobe never pull ser_cs_n low.
- R4: An update sampled while busy is 0 makes busy 1 and ser_cs_n 0 on the next clock edge.
- R5: During a frame, ser_sclk repeats with a period of 8 system clocks: 4 clocks low, then 4 clocks high. Whenever ser_cs_n is 1, ser_sclk is 0.
- R6: The word is sent most significant bit first. ser_sdo is sampled on each rising edge of ser_sclk, and it does not change while ser_sclk is high.
- R7: The first rising edge of ser_sclk comes 12 system clocks after ser_cs_n falls. ser_cs_n stays low for exactly 208 system clocks, which is one serial period before the bits, 24 bit periods, and one serial period after them.
- R8: busy falls in the same cycle that ser_cs_n rises, and busy stays 1 for as long as ser_cs_n is 0.
- R9: An update that arrives while busy is 1 is ignored. The frame in progress keeps its length, and no extra frame follows it.
- R10: Host writes made during a frame do not change the bits of that frame. They appear in the next frame.
- R11: Each frame contains exactly 24 rising edges of ser_sclk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_hi | input | 1 | 1 selects the upper 16 bits, 0 selects the lower 8 bits |
| wr_data | input | 16 | Host write data |
| update | input | 1 | Starts a serial transfer of the staged word |
| busy | output | 1 | High while a frame is in progress |
| ser_cs_n | output | 1 | Active-low serial chip select |
| ser_sclk | output | 1 | Serial clock, idles low |
| ser_sdo | output | 1 | Serial data, most significant bit first |

## Verification
Frames are sent with all-ones, all-zeros and alternating-bit words, with a word that has only its two end bits set, and with the full-scale 10-bit wiper value. These patterns separate bit-order errors, stuck data lines, a dropped first or last bit, and a swap of the two halves. A lower write with a non-zero upper bus byte, followed by a frame after an upper-only write, shows that the unused byte is masked and that each half is held on its own. An update pulse in the middle of a frame shows whether a busy start is really ignored. Host writes in the middle of a frame show whether the shift register was loaded at the update or is still reading the live staging register.

// File: rtl/pot_loader_pkg.sv
package pot_loader_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_LEAD  = 2'd1,
        TX_SHIFT = 2'd2,
        TX_TRAIL = 2'd3
    } tx_state_e;

endpackage

// File: rtl/pot_stage_reg.sv
// Holds the two host-written halves of the potentiometer setup word.
module pot_stage_reg #(
    parameter int BUS_W = 16,
    parameter int LO_W  = 8,
    localparam int WORD_W = BUS_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        logic [BUS_W-1:0] hi;
        logic [LO_W-1:0]  lo;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (wr_hi) begin
                s_d.hi = wr_data;
            end else begin
                s_d.lo = wr_data[LO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word = {s_q.hi, s_q.lo};

endmodule

// File: rtl/pot_phase_ctr.sv
// Counts system clocks inside one serial-clock period.
module pot_phase_ctr #(
    parameter int DIV = 8,
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic period_end,
    output logic high_half
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ph_t;

    ph_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (clr || (p_q.phase == PH_LAST)) begin
            p_d.phase = '0;
        end else begin
            p_d.phase = p_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign period_end = (p_q.phase == PH_LAST);
    assign high_half  = (p_q.phase >= PH_HALF);

endmodule

// File: rtl/pot_serial_fsm.sv
// Frames a latched word onto the three-wire link.
module pot_serial_fsm
    import pot_loader_pkg::*;
#(
    parameter int WORD_W = 24,
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] load_word,
    input  logic              period_end,
    input  logic              high_half,
    output logic              clr_phase,
    output logic              busy,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdo
);

    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_W - 1);

    typedef struct packed {
        tx_state_e         state;
        logic [WORD_W-1:0] shreg;
        logic [BIT_W-1:0]  bits_left;
    } fsm_t;

    fsm_t f_d, f_q;
    logic accept;

    assign accept    = start && (f_q.state == TX_IDLE);
    assign clr_phase = accept;

    always_comb begin
        f_d = f_q;
        unique case (f_q.state)
            TX_IDLE: begin
                if (start) begin
                    f_d.state     = TX_LEAD;
                    f_d.shreg     = load_word;
                    f_d.bits_left = LAST_IDX;
                end
            end
            TX_LEAD: begin
                if (period_end) begin
                    f_d.state = TX_SHIFT;
                end
            end
            TX_SHIFT: begin
                if (period_end) begin
                    if (f_q.bits_left == '0) begin
                        f_d.state = TX_TRAIL;
                    end else begin
                        f_d.shreg     = {f_q.shreg[WORD_W-2:0], 1'b0};
                        f_d.bits_left = f_q.bits_left - 1'b1;
                    end
                end
            end
            TX_TRAIL: begin
                if (period_end) begin
                    f_d.state = TX_IDLE;
                end
            end
            default: f_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '{state: TX_IDLE, shreg: '0, bits_left: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign busy = (f_q.state != TX_IDLE);
    assign cs_n = (f_q.state == TX_IDLE);
    assign sclk = (f_q.state == TX_SHIFT) && high_half;
    assign sdo  = (f_q.state == TX_SHIFT) && f_q.shreg[WORD_W-1];

endmodule

// File: rtl/pot_word_loader.sv
// Top: split-word staging plus framed serial transfer.
module pot_word_loader #(
    parameter int BUS_W = 16,
    parameter int LO_W  = 8,
    parameter int DIV   = 8,
    localparam int WORD_W = BUS_W + LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             update,
    output logic             busy,
    output logic             ser_cs_n,
    output logic             ser_sclk,
    output logic             ser_sdo
);

    logic [WORD_W-1:0] staged_word;
    logic              clr_phase;
    logic              period_end;
    logic              high_half;

    pot_stage_reg #(
        .BUS_W (BUS_W),
        .LO_W  (LO_W)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .word    (staged_word)
    );

    pot_phase_ctr #(
        .DIV (DIV)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_phase),
        .period_end (period_end),
        .high_half  (high_half)
    );

    pot_serial_fsm #(
        .WORD_W (WORD_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (update),
        .load_word  (staged_word),
        .period_end (period_end),
        .high_half  (high_half),
        .clr_phase  (clr_phase),
        .busy       (busy),
        .cs_n       (ser_cs_n),
        .sclk       (ser_sclk),
        .sdo        (ser_sdo)
    );

endmodule

// File: rtl/pot_word_loader_chk.sv
// Protocol checker bound to the loader top.
module pot_word_loader_chk #(
    parameter int WORD_W = 24,
    parameter int DIV    = 8,
    localparam int FRAME = DIV * (WORD_W + 2),
    localparam int FC_W  = $clog2(FRAME + 1),
    localparam int RC_W  = $clog2(WORD_W + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic update,
    input logic busy,
    input logic ser_cs_n,
    input logic ser_sclk,
    input logic ser_sdo
);

    logic [FC_W-1:0] busy_cnt_q;
    logic [RC_W-1:0] rise_cnt_q;
    logic            sclk_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt_q  <= '0;
            rise_cnt_q  <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= ser_sclk;
            busy_cnt_q  <= busy ? busy_cnt_q + 1'b1 : '0;
            if (!busy) begin
                rise_cnt_q <= '0;
            end else if (ser_sclk && !sclk_prev_q) begin
                rise_cnt_q <= rise_cnt_q + 1'b1;
            end
        end
    end

    assert_update_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (update && !busy) |=> (busy && !ser_cs_n));

    assert_idle_sclk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cs_n |-> !ser_sclk);

    assert_sdo_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sclk |-> $stable(ser_sdo));

    // Also covers R9: an ignored update must not stretch the frame.
    assert_frame_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt_q == FC_W'(FRAME)));

    assert_busy_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $rose(ser_cs_n));

    assert_bit_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rise_cnt_q == RC_W'(WORD_W)));

endmodule

bind pot_word_loader pot_word_loader_chk #(
    .WORD_W (WORD_W),
    .DIV    (DIV)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .update   (update),
    .busy     (busy),
    .ser_cs_n (ser_cs_n),
    .ser_sclk (ser_sclk),
    .ser_sdo  (ser_sdo)
);

// File: tb/sim_pot_word_loader.sv
module sim_pot_word_loader;

    localparam int DIV       = 8;
    localparam int WORD_W    = 24;
    localparam int FRAME     = DIV * (WORD_W + 2);
    localparam int LEAD_RISE = DIV + DIV / 2 + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [15:0] wr_data = '0;
    logic        update = 1'b0;
    logic        busy, ser_cs_n, ser_sclk, ser_sdo;

    always #2 clk = ~clk;

    pot_word_loader u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_hi    (wr_hi),
        .wr_data  (wr_data),
        .update   (update),
        .busy     (busy),
        .ser_cs_n (ser_cs_n),
        .ser_sclk (ser_sclk),
        .ser_sdo  (ser_sdo)
    );

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    int frames_exp = 0;
    logic [23:0] exp_q[$];
    logic [15:0] m_hi = '0;
    logic [7:0]  m_lo = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- monitor / scoreboard ----------------
    logic        prev_cs = 1'b1, prev_sclk = 1'b0, prev_sdo = 1'b0;
    bit          in_frame = 0, hold_bad = 0, spacing_bad = 0, busy_bad = 0, idle_bad = 0;
    int          lo_cnt = 0, bits = 0, last_rise = 0, hi_run = 0;
    logic [23:0] word = '0;
    logic [23:0] exp_w;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_cs_n && ser_sclk) idle_bad = 1;
            if (prev_cs && !ser_cs_n) begin
                in_frame = 1; lo_cnt = 0; bits = 0; word = '0; hi_run = 0;
                hold_bad = 0; spacing_bad = 0; busy_bad = 0;
            end
            if (!ser_cs_n) begin
                lo_cnt++;
                if (!busy) busy_bad = 1;
                if (ser_sclk && !prev_sclk) begin
                    bits++;
                    word = {word[22:0], ser_sdo};
                    if (bits == 1)
                        check(lo_cnt == LEAD_RISE, "R7", "first sclk rise position", lo_cnt, LEAD_RISE);
                    else if (lo_cnt - last_rise != DIV)
                        spacing_bad = 1;
                    last_rise = lo_cnt;
                end
                if (ser_sclk) hi_run++;
                if (!ser_sclk && prev_sclk) begin
                    if (hi_run != DIV / 2) spacing_bad = 1;
                    hi_run = 0;
                end
                if (ser_sclk && prev_sclk && ser_sdo != prev_sdo) hold_bad = 1;
            end
            if (!prev_cs && ser_cs_n && in_frame) begin
                in_frame = 0;
                frames_seen++;
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected frame", frames_seen, frames_exp);
                end else begin
                    exp_w = exp_q.pop_front();
                    check(word == exp_w, "R6", "frame word msb first", word, exp_w);
                end
                check(bits == WORD_W, "R11", "sclk rises per frame", bits, WORD_W);
                check(lo_cnt == FRAME, "R7", "cs_n low length", lo_cnt, FRAME);
                check(!spacing_bad, "R5", "sclk 4 low / 4 high", spacing_bad, 0);
                check(!hold_bad, "R6", "sdo held while sclk high", hold_bad, 0);
                check(!busy_bad && !busy, "R8", "busy tracks cs_n", busy, 0);
            end
            prev_cs = ser_cs_n; prev_sclk = ser_sclk; prev_sdo = ser_sdo;
        end
    end

    // ---------------- driver ----------------
    task automatic host_wr(input bit hi, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        if (hi) m_hi = d; else m_lo = d[7:0];
        @(negedge clk);
        wr_en = 1'b0; wr_hi = 1'b0; wr_data = '0;
    endtask

    task automatic go();
        @(negedge clk);
        while (busy) @(negedge clk);
        update = 1'b1;
        exp_q.push_back({m_hi, m_lo});
        frames_exp++;
        @(negedge clk);
        update = 1'b0;
        check(busy && !ser_cs_n, "R4", "busy/cs after update", {busy, ser_cs_n}, 2'b10);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] hi, input logic [15:0] lo);
        host_wr(1'b1, hi);
        host_wr(1'b0, lo);
        go();
        wait_idle();
    endtask

    task automatic finish_run();
        check(!idle_bad, "R5", "sclk low while cs_n high", idle_bad, 0);
        check(frames_seen == frames_exp && exp_q.size() == 0, "R9", "frame count",
              frames_seen, frames_exp);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && ser_cs_n && !ser_sclk && !ser_sdo, "R1", "reset outputs",
              {busy, ser_cs_n, ser_sclk, ser_sdo}, 4'b0100);

        // R3: writes alone start nothing
        host_wr(1'b1, 16'h1357);
        host_wr(1'b0, 16'h0024);
        repeat (50) @(negedge clk);
        check(frames_seen == 0 && ser_cs_n && !busy, "R3", "no frame without update",
              frames_seen, 0);

        // Data patterns (R6)
        send(16'hFFFF, 16'h00FF);
        send(16'h0000, 16'h0000);
        send(16'hA5C3, 16'h005A);
        send(16'h8000, 16'h0001);
        send(16'h0003, 16'h00FF);   // full-scale 10-bit wiper

        // R2: upper bus byte ignored on lower write, halves held separately
        host_wr(1'b0, 16'hAB12);
        go(); wait_idle();
        host_wr(1'b1, 16'h1234);
        go(); wait_idle();

        // R9: update while busy is ignored
        host_wr(1'b1, 16'h0F0F);
        host_wr(1'b0, 16'h00F0);
        go();
        repeat (60) @(negedge clk);
        update = 1'b1;
        @(negedge clk);
        update = 1'b0;
        wait_idle();
        repeat (30) @(negedge clk);
        check(frames_seen == frames_exp, "R9", "no extra frame after busy update",
              frames_seen, frames_exp);

        // R10: writes during a frame do not disturb it
        host_wr(1'b1, 16'hC001);
        host_wr(1'b0, 16'h0080);
        go();
        repeat (40) @(negedge clk);
        host_wr(1'b1, 16'h5AA5);
        host_wr(1'b0, 16'h003C);
        wait_idle();
        check(frames_seen == frames_exp, "R10", "frame with mid-write done",
              frames_seen, frames_exp);
        go(); wait_idle();

        finish_run();
    end

endmodule